// File: doc/BRIEF.md
# Link Status Configuration Word Exchange

This block carries link status across a serial gigabit link as 16-bit configuration words, one level above the line code. One parameter picks the side it sits on. On the PHY side it watches three status inputs: link up, full duplex and a two-bit speed. When any of them moves, the block leaves data mode and streams a configuration word that carries the new status. It keeps sending until the partner acknowledges. It then stays in configuration mode for one more link timer period before it returns to data mode.

On the MAC side the block watches incoming configuration words. A word must arrive unchanged on several consecutive accepted strobes before the block trusts it. It then decodes the word and latches the status onto its outputs. From that point it streams the fixed acknowledge word. When the partner stops sending configuration words for one link timer period, the MAC side drops back to data mode.

The link timer is counted in clock cycles. A 125 MHz clock needs 200000 cycles for the 1.6 ms period. A simulation can shorten the timer to a few cycles.

Top module: `cfg_word_handshake`

## Requirements
- R1: The PHY side sends its status in this word layout: bit 15 = link (1 up), bit 12 = duplex (1 full), bits 11:10 = speed (2'b10 1000 Mb/s, 2'b01 100 Mb/s, 2'b00 10 Mb/s, 2'b11 reserved), bit 0 = 1, and every other bit 0. When the block is not in configuration mode, the transmit word reads 0.
- R2: On the PHY side in data mode, a change of link, duplex or speed at a clock edge makes `cfg_mode` and `tx_valid` high from that edge on, and `tx_word` then carries the new status.
- R3: On the PHY side, an acknowledge is a receive strobe whose word has bit 14 and bit 0 set. Once the acknowledge is taken, the block stays in configuration mode for exactly TIMER_CYCLES cycles and then returns to data mode, with `cfg_mode` = 0 and `tx_valid` = 0.
- R4: On the PHY side, a status change during an exchange restarts the exchange. This holds whether the block is waiting for the acknowledge or holding after it. The word updates at the next edge and the block waits for a fresh acknowledge. If an acknowledge arrives in the same cycle as a change, the acknowledge is disregarded.
- R5: On the PHY side, a receive strobe whose word lacks bit 14 or bit 0 does not end the wait for an acknowledge.
- R6: On the MAC side, a strobe is accepted only when bit 0 of its word is 1. A strobe with bit 0 = 0 is ignored entirely: it neither counts nor breaks a run. The status outputs change only when the same word has been accepted CONFIRM_COUNT times in a row. An accepted word that differs from the previous one starts a new run of length 1.
- R7: On the MAC side, at the edge that latches a status, `cfg_mode` and `tx_valid` go high and `tx_word` = 16'h4001. The latched link, duplex and speed then follow the R1 layout.
- R8: On the MAC side, an accepted word that differs from the previous accepted word drops `tx_valid` and `cfg_mode` at the next edge.
- R9: On the MAC side, the acknowledge stays up while accepted strobes keep coming. It drops after TIMER_CYCLES consecutive cycles without an accepted strobe, and the latched status is kept. A further accepted copy of the completed word raises the acknowledge again at once.
- R10: After reset, every output is 0.
- R11: On the PHY side, `link_out`, `duplex_out` and `speed_out` show the status last taken into a configuration word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_in | input | 1 | PHY side: link up |
| duplex_in | input | 1 | PHY side: full duplex |
| speed_in | input | 2 | PHY side: speed code |
| rx_word | input | 16 | Received configuration word |
| rx_valid | input | 1 | Strobe for rx_word |
| tx_word | output | 16 | Configuration word to send |
| tx_valid | output | 1 | Strobe for tx_word |
| cfg_mode | output | 1 | 1 = configuration mode, 0 = data mode |
| link_out | output | 1 | Link state: latched (MAC side) or advertised (PHY side) |
| duplex_out | output | 1 | Duplex: latched (MAC side) or advertised (PHY side) |
| speed_out | output | 2 | Speed code: latched (MAC side) or advertised (PHY side) |

## Verification
On the PHY side, a status change and an acknowledge can arrive in the same cycle. The bench drives both at the same falling edge and expects the restart to win: the block stays waiting with the new word and never enters the hold period. On the MAC side, an accepted strobe and the idle expiry compete at a timer boundary, so strobes are spaced just inside the timer period to show that each one resets the idle count. A behavioural model in the bench follows each side through every cycle and is compared with all outputs at each falling edge.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   localparam int ROLE_PHY = 0;
   localparam int ROLE_MAC = 1;

   localparam int          ACK_BIT  = 14;
   localparam logic [15:0] ACK_WORD = 16'h4001;

   typedef struct packed {
      logic       link;
      logic       duplex;
      logic [1:0] speed;
   } lstat_t;

   typedef enum logic [1:0] {
      PH_DATA = 2'd0,
      PH_WAIT = 2'd1,
      PH_HOLD = 2'd2
   } phy_st_e;

   // Build the status word: link at 15, duplex at 12, speed at 11:10, bit 0 set.
   function automatic logic [15:0] pack_status(lstat_t s);
      return {s.link, 2'b00, s.duplex, s.speed, 9'd0, 1'b1};
   endfunction

endpackage

// File: rtl/cfgx_timer.sv
module cfgx_timer #(
   parameter int unsigned CYCLES = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   output logic expired
);
   localparam int unsigned CW = $clog2(CYCLES + 1);

   if (CYCLES < 2) begin : g_bad_len
      $error("cfgx_timer: CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign expired = run && !clear && (cnt == CW'(CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || clear)  cnt <= '0;
      else if (!expired)       cnt <= cnt + CW'(1);
   end

   // R3
   no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(CYCLES - 1));

endmodule

// File: rtl/cfgx_phy_side.sv
module cfgx_phy_side
   import cfgx_pkg::*;
#(
   parameter int unsigned TIMER_CYCLES = 200000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  lstat_t      live,
   input  logic        ack_in,
   output logic        tx_valid,
   output logic [15:0] tx_word,
   output logic        cfg_mode,
   output lstat_t      adv
);
   phy_st_e state;
   lstat_t  snap;
   logic    changed;
   logic    hold_done;

   assign changed = (live != snap);

   cfgx_timer #(.CYCLES(TIMER_CYCLES)) u_hold_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state == PH_HOLD),
      .clear   (1'b0),
      .expired (hold_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= PH_DATA;
         snap  <= '0;
      end else begin
         unique case (state)
            PH_DATA: if (changed) begin
               snap  <= live;
               state <= PH_WAIT;
            end
            PH_WAIT: begin
               if (changed)     snap  <= live;
               else if (ack_in) state <= PH_HOLD;
            end
            PH_HOLD: begin
               if (changed) begin
                  snap  <= live;
                  state <= PH_WAIT;
               end else if (hold_done) begin
                  state <= PH_DATA;
               end
            end
            default: state <= PH_DATA;
         endcase
      end
   end

   assign cfg_mode = (state != PH_DATA);
   assign tx_valid = cfg_mode;
   assign tx_word  = cfg_mode ? pack_status(snap) : 16'h0000;
   assign adv      = snap;

   // R2
   change_enters_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_DATA && changed) |=> (cfg_mode && tx_word == pack_status($past(live))));

   // R4
   restart_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != PH_DATA && changed) |=> (state == PH_WAIT));

   // R3
   ack_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_WAIT && ack_in && !changed) |=> (state == PH_HOLD));

   // R3
   hold_exit_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_mode) |-> $past(hold_done));

   // R5
   no_ack_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_WAIT && !ack_in) |=> cfg_mode);

endmodule

// File: rtl/cfgx_mac_side.sv
module cfgx_mac_side
   import cfgx_pkg::*;
#(
   parameter int unsigned TIMER_CYCLES  = 200000,
   parameter int unsigned CONFIRM_COUNT = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_valid,
   input  logic [15:0] rx_word,
   output logic        tx_valid,
   output logic [15:0] tx_word,
   output logic        cfg_mode,
   output lstat_t      latched
);
   localparam int unsigned NW = $clog2(CONFIRM_COUNT + 1);

   if (CONFIRM_COUNT < 2) begin : g_bad_confirm
      $error("cfgx_mac_side: CONFIRM_COUNT must be at least 2");
   end

   logic [15:0]   cand;
   logic [NW-1:0] run_cnt;
   logic          ack_on;
   logic          accept;
   logic          same;
   logic          idle_exp;

   assign accept = rx_valid && rx_word[0];
   assign same   = (rx_word == cand);

   cfgx_timer #(.CYCLES(TIMER_CYCLES)) u_idle_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ack_on),
      .clear   (accept),
      .expired (idle_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand    <= '0;
         run_cnt <= '0;
         ack_on  <= 1'b0;
         latched <= '0;
      end else if (accept) begin
         if (same) begin
            if (run_cnt != NW'(CONFIRM_COUNT)) run_cnt <= run_cnt + NW'(1);
            if (run_cnt >= NW'(CONFIRM_COUNT - 1)) begin
               latched.link   <= rx_word[15];
               latched.duplex <= rx_word[12];
               latched.speed  <= rx_word[11:10];
               ack_on         <= 1'b1;
            end
         end else begin
            cand    <= rx_word;
            run_cnt <= NW'(1);
            ack_on  <= 1'b0;
         end
      end else if (idle_exp) begin
         ack_on <= 1'b0;
      end
   end

   assign tx_valid = ack_on;
   assign cfg_mode = ack_on;
   assign tx_word  = ack_on ? ACK_WORD : 16'h0000;

   // R6
   latch_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(latched) |-> $past(accept && same));

   // R6
   ignore_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_word[0]) |=> ($stable(latched) && $stable(cand)));

   // R8
   mismatch_drops_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !same) |=> !tx_valid);

   // R7
   ack_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_word[ACK_BIT] && tx_word[0]));

   // R9
   idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_on) |-> $past(accept || idle_exp));

endmodule

// File: rtl/cfg_word_handshake.sv
module cfg_word_handshake
   import cfgx_pkg::*;
#(
   parameter int          ROLE          = 0,
   parameter int unsigned TIMER_CYCLES  = 200000,
   parameter int unsigned CONFIRM_COUNT = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        link_in,
   input  logic        duplex_in,
   input  logic [1:0]  speed_in,
   input  logic [15:0] rx_word,
   input  logic        rx_valid,
   output logic [15:0] tx_word,
   output logic        tx_valid,
   output logic        cfg_mode,
   output logic        link_out,
   output logic        duplex_out,
   output logic [1:0]  speed_out
);
   lstat_t st_out;

   assign link_out   = st_out.link;
   assign duplex_out = st_out.duplex;
   assign speed_out  = st_out.speed;

   if (ROLE != ROLE_PHY && ROLE != ROLE_MAC) begin : g_bad_role
      $error("cfg_word_handshake: ROLE must be 0 (PHY) or 1 (MAC)");
   end

   if (ROLE == ROLE_PHY) begin : g_phy
      lstat_t live_st;
      logic   ack_in;
      logic   unused_rx_bits;

      assign live_st        = '{link: link_in, duplex: duplex_in, speed: speed_in};
      assign ack_in         = rx_valid && rx_word[ACK_BIT] && rx_word[0];
      assign unused_rx_bits = ^{rx_word[15], rx_word[13:1]};

      cfgx_phy_side #(.TIMER_CYCLES(TIMER_CYCLES)) u_phy (
         .clk      (clk),
         .rst_n    (rst_n),
         .live     (live_st),
         .ack_in   (ack_in),
         .tx_valid (tx_valid),
         .tx_word  (tx_word),
         .cfg_mode (cfg_mode),
         .adv      (st_out)
      );
   end else begin : g_mac
      logic unused_phy_in;

      assign unused_phy_in = ^{link_in, duplex_in, speed_in};

      cfgx_mac_side #(
         .TIMER_CYCLES  (TIMER_CYCLES),
         .CONFIRM_COUNT (CONFIRM_COUNT)
      ) u_mac (
         .clk      (clk),
         .rst_n    (rst_n),
         .rx_valid (rx_valid),
         .rx_word  (rx_word),
         .tx_valid (tx_valid),
         .tx_word  (tx_word),
         .cfg_mode (cfg_mode),
         .latched  (st_out)
      );
   end

   // R10
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!tx_valid && !cfg_mode));

endmodule

// File: tb/tb_cfg_word_handshake.sv
module tb_cfg_word_handshake;
   localparam int T = 12;
   localparam int C = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   // PHY-side instance
   logic        p_link = 0, p_dup = 0;
   logic [1:0]  p_spd = 0;
   logic [15:0] p_rxw = 0;
   logic        p_rxv = 0;
   logic [15:0] p_txw;
   logic        p_txv, p_cfg, p_lo, p_do;
   logic [1:0]  p_so;

   // MAC-side instance
   logic [15:0] m_rxw = 0;
   logic        m_rxv = 0;
   logic [15:0] m_txw;
   logic        m_txv, m_cfg, m_lo, m_do;
   logic [1:0]  m_so;

   cfg_word_handshake #(.ROLE(0), .TIMER_CYCLES(T), .CONFIRM_COUNT(C)) dut (
      .clk(clk), .rst_n(rst_n), .link_in(p_link), .duplex_in(p_dup), .speed_in(p_spd),
      .rx_word(p_rxw), .rx_valid(p_rxv), .tx_word(p_txw), .tx_valid(p_txv),
      .cfg_mode(p_cfg), .link_out(p_lo), .duplex_out(p_do), .speed_out(p_so));

   cfg_word_handshake #(.ROLE(1), .TIMER_CYCLES(T), .CONFIRM_COUNT(C)) dut_mac (
      .clk(clk), .rst_n(rst_n), .link_in(1'b0), .duplex_in(1'b0), .speed_in(2'b00),
      .rx_word(m_rxw), .rx_valid(m_rxv), .tx_word(m_txw), .tx_valid(m_txv),
      .cfg_mode(m_cfg), .link_out(m_lo), .duplex_out(m_do), .speed_out(m_so));

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 0;
   string preq   = "R10";
   string mreq   = "R10";

   // behavioural reference: PHY side
   int         ph_mode;   // 0 data, 1 waiting, 2 holding
   int         ph_cnt;
   logic [3:0] ph_st;     // {link, duplex, speed}

   // behavioural reference: MAC side
   logic [15:0] mc_last;
   int          mc_run;
   int          mc_idle;
   bit          mc_ack;
   logic [3:0]  mc_st;

   function automatic logic [15:0] word_of(logic [3:0] s);
      return (16'(s[3]) << 15) | (16'(s[2]) << 12) | (16'(s[1:0]) << 10) | 16'h0001;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ph_mode = 0; ph_cnt = 0; ph_st = 4'h0;
         mc_last = 16'h0; mc_run = 0; mc_idle = 0; mc_ack = 0; mc_st = 4'h0;
      end else begin
         logic [3:0] now_st;
         bit         moved, ackd;
         now_st = {p_link, p_dup, p_spd};
         moved  = (now_st != ph_st);
         ackd   = p_rxv && p_rxw[14] && p_rxw[0];
         if (moved) begin
            ph_st   = now_st;
            ph_mode = 1;
         end else if (ph_mode == 1 && ackd) begin
            ph_mode = 2; ph_cnt = 0;
         end else if (ph_mode == 2) begin
            if (ph_cnt == T - 1) ph_mode = 0;
            else ph_cnt++;
         end

         if (m_rxv && m_rxw[0]) begin
            mc_idle = 0;
            if (mc_run > 0 && m_rxw == mc_last) begin
               if (mc_run < C) mc_run++;
               if (mc_run == C) begin
                  mc_st  = {m_rxw[15], m_rxw[12], m_rxw[11:10]};
                  mc_ack = 1;
               end
            end else begin
               mc_last = m_rxw; mc_run = 1; mc_ack = 0;
            end
         end else if (mc_ack) begin
            if (mc_idle == T - 1) mc_ack = 0;
            else mc_idle++;
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         logic [15:0] ew;
         bit          ec;
         ec = (ph_mode != 0);
         ew = ec ? word_of(ph_st) : 16'h0;
         checks++;
         if (p_cfg !== ec || p_txv !== ec || p_txw !== ew || {p_lo, p_do, p_so} !== ph_st) begin
            fails++;
            $display("FAIL %s phy: cfg=%0b v=%0b w=%h st=%h expected cfg=%0b v=%0b w=%h st=%h",
                     preq, p_cfg, p_txv, p_txw, {p_lo, p_do, p_so}, ec, ec, ew, ph_st);
         end
         ew = mc_ack ? 16'h4001 : 16'h0;
         checks++;
         if (m_cfg !== mc_ack || m_txv !== mc_ack || m_txw !== ew || {m_lo, m_do, m_so} !== mc_st) begin
            fails++;
            $display("FAIL %s mac: cfg=%0b v=%0b w=%h st=%h expected cfg=%0b v=%0b w=%h st=%h",
                     mreq, m_cfg, m_txv, m_txw, {m_lo, m_do, m_so}, mc_ack, mc_ack, ew, mc_st);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic phy_ack;
      p_rxv = 1; p_rxw = 16'h4001; tick(1); p_rxv = 0; p_rxw = 0;
   endtask

   task automatic mac_send(input logic [15:0] w, input int gap);
      m_rxv = 1; m_rxw = w; tick(1); m_rxv = 0; m_rxw = 0; tick(gap);
   endtask

   task automatic phy_seq;
      preq = "R1 R2 R11"; p_link = 1; p_dup = 1; p_spd = 2'b10; tick(4);
      preq = "R5"; p_rxv = 1; p_rxw = 16'h0001; tick(3);
      p_rxw = 16'h4000; tick(2);
      p_rxw = 16'h8001; tick(2); p_rxv = 0; p_rxw = 0; tick(1);
      preq = "R3"; phy_ack(); tick(T + 4);
      preq = "R2 R1"; p_spd = 2'b01; tick(3);
      preq = "R4"; p_dup = 0; tick(2);
      phy_ack(); tick(4);
      p_link = 0; tick(3);
      // change and acknowledge in the same cycle: restart wins
      p_rxv = 1; p_rxw = 16'h4001; p_spd = 2'b00; tick(1); p_rxv = 0; p_rxw = 0; tick(3);
      preq = "R3 R11"; phy_ack(); tick(T + 3);
      preq = "R1 R2"; p_link = 1; p_spd = 2'b11; tick(2); phy_ack(); tick(T + 2);
   endtask

   task automatic mac_seq;
      mreq = "R6"; mac_send(16'h9801, 1); mac_send(16'h9801, 1);
      mac_send(16'h9800, 1);
      mreq = "R7"; mac_send(16'h9801, 2);
      mreq = "R9"; mac_send(16'h9801, T - 2); mac_send(16'h9801, T - 2);
      mac_send(16'h9801, T + 3);
      mac_send(16'h9801, 2);
      mreq = "R8"; mac_send(16'h8401, 2); mac_send(16'h8401, 0); mac_send(16'h8401, 3);
      mreq = "R6"; mac_send(16'h8001, 0); mac_send(16'h8001, 0); mac_send(16'h8401, 0);
      mac_send(16'h8001, 0); mac_send(16'h8001, 2); mac_send(16'h8001, 3);
      mreq = "R9"; tick(T + 3);
   endtask

   initial begin
      tick(3);
      rst_n = 1;
      tick(2);
      fork
         phy_seq();
         mac_seq();
      join
      tick(2);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule